// File: doc/BRIEF.md
# Software-Managed Scratchpad with Implicit Register Operands

This block is a small on-chip scratchpad that a compiler manages explicitly. It sits next to the register file and runs a 9-bit scratchpad instruction. Two operations are defined: a load that copies scratchpad contents into the two fixed data registers R6 and R7, and a store that copies R6 and R7 into the scratchpad. The storage has four lines, and each line holds two 6-bit words, which gives eight words in total.

A mode bit in the instruction picks the access size. A single access moves one word to or from R6. A double access moves a whole line, with the even word going to R6 and the odd word going to R7. The register file supplies the current R6 and R7 values on every cycle. The block returns write-back data and write enables for both registers exactly one cycle after the instruction, so access time never varies. Stores take effect at the clock edge on which the instruction is accepted.

Top module: `scratch_ldst`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, and in the first cycle after it, both write enables, both data outputs and the index error flag are 0. Every stored word reads back as 0 after reset.
- R2: The instruction layout is: bits [8:6] are the opcode, with 3'b101 for load and 3'b110 for store; bit [5] is the mode, where 1 means double and 0 means single; bits [4:0] are the index. An instruction is acted on only when `ins_valid` is 1.
- R3: A single load reads word number index[2:0], where word number = 2*line + slot. The word appears on `r6_wdata` with `r6_we`=1 exactly one cycle later. `r7_we` stays 0.
- R4: A double load of line index[1:0] returns the even word on `r6_wdata` and the odd word on `r7_wdata` one cycle later, with both enables at 1.
- R5: A single store writes `r6_in` into word index[2:0] at the accepting edge. It raises neither write enable.
- R6: A double store writes `r6_in` into the even word and `r7_in` into the odd word of line index[1:0]. It raises neither write enable.
- R7: In double mode, index bits [4:2] are ignored for addressing. If any of them is nonzero, `idx_err` is 1 for one cycle, one cycle after the instruction. A single access never raises `idx_err`.
- R8: A load in the cycle right after a store to the same word returns the newly stored value.
- R9: An instruction with any other opcode, or with `ins_valid` at 0, leaves all storage unchanged and raises no enable and no error.
- R10: Write enables are single-cycle pulses that follow only load instructions, with a fixed latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins | input | 9 | Scratchpad instruction |
| r6_in | input | 6 | Current value of R6 |
| r7_in | input | 6 | Current value of R7 |
| r6_we | output | 1 | Write enable for R6 |
| r6_wdata | output | 6 | Write-back data for R6 |
| r7_we | output | 1 | Write enable for R7 |
| r7_wdata | output | 6 | Write-back data for R7 |
| idx_err | output | 1 | Double-mode index had nonzero upper bits |

## Verification
A long run of random instructions mixes every opcode value, both modes and all 32 index values against a word-level model. This separates the single-mode word mapping from the double-mode line mapping, and it separates the even and odd slots that belong to R6 and R7. Directed sequences cover four cases: read-back of a freshly reset store, a store followed at once by a load of the same word (which tells write-before-read from stale data), double accesses with upper index bits set (which separates alias handling from error reporting), and idle or unknown opcodes followed by a full dump of the storage to show nothing changed.

// File: rtl/scratch_ldst_pkg.sv
package scratch_ldst_pkg;

    // Geometry of the scratchpad
    localparam int WORD_W  = 6;
    localparam int LINES   = 4;
    localparam int SLOTS   = 2;

    // Instruction layout
    localparam int OP_W    = 3;
    localparam int IDX_W   = 5;
    localparam int INSTR_W = OP_W + 1 + IDX_W;

    // Derived address widths
    localparam int LINE_AW = $clog2(LINES);
    localparam int SLOT_AW = $clog2(SLOTS);
    localparam int WORD_AW = LINE_AW + SLOT_AW;
    localparam int WORDS   = LINES * SLOTS;

    // Bit positions inside the instruction
    localparam int OP_LSB   = IDX_W + 1;
    localparam int MODE_BIT = IDX_W;

    // Opcode values
    localparam logic [OP_W-1:0] OPC_LOAD  = 3'b101;
    localparam logic [OP_W-1:0] OPC_STORE = 3'b110;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic               rd;
        logic               wr;
        logic               dbl;
        logic [LINE_AW-1:0] line;
        logic [SLOT_AW-1:0] slot;
        logic               range_err;
    } req_t;

    typedef struct packed {
        logic  we_lo;
        logic  we_hi;
        word_t d_lo;
        word_t d_hi;
        logic  err;
    } resp_t;

    // Turn a raw instruction into an access request
    function automatic req_t decode_instr(input logic valid,
                                          input logic [INSTR_W-1:0] ins);
        req_t                r;
        logic [OP_W-1:0]     op;
        logic [IDX_W-1:0]    idx;
        op  = ins[INSTR_W-1:OP_LSB];
        idx = ins[IDX_W-1:0];
        r.rd  = valid && (op == OPC_LOAD);
        r.wr  = valid && (op == OPC_STORE);
        r.dbl = ins[MODE_BIT];
        if (ins[MODE_BIT]) begin
            r.line      = idx[LINE_AW-1:0];
            r.slot      = '0;
            r.range_err = (r.rd || r.wr) && (|idx[IDX_W-1:LINE_AW]);
        end else begin
            r.line      = idx[WORD_AW-1:SLOT_AW];
            r.slot      = idx[SLOT_AW-1:0];
            r.range_err = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/scratch_ldst_decode.sv
module scratch_ldst_decode
    import scratch_ldst_pkg::*;
(
    input  logic               ins_valid,
    input  logic [INSTR_W-1:0] ins,
    output req_t               req
);
    always_comb begin
        req = decode_instr(ins_valid, ins);
    end

    always_comb begin
        assert (!(req.rd && req.wr)) else $error("p_one_op_r2 violated");
    end
endmodule

// File: rtl/scratch_ldst_bank.sv
module scratch_ldst_bank
    import scratch_ldst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  req_t  req,
    input  word_t lo_in,
    input  word_t hi_in,
    output word_t rd_lo,
    output word_t rd_hi
);
    word_t                   mem [LINES][SLOTS];
    logic [WORDS*WORD_W-1:0] mem_flat;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic  wen;
            word_t wdat;
            always_comb begin
                wen  = req.wr && (req.line == l[LINE_AW-1:0]) &&
                       (req.dbl || (req.slot == s[SLOT_AW-1:0]));
                wdat = (req.dbl && (s != 0)) ? hi_in : lo_in;
            end
            always_ff @(posedge clk) begin
                if (rst)      mem[l][s] <= '0;
                else if (wen) mem[l][s] <= wdat;
            end
            assign mem_flat[(l*SLOTS+s)*WORD_W +: WORD_W] = mem[l][s];
        end
    end

    always_comb begin
        if (req.dbl) begin
            rd_lo = mem[req.line][0];
            rd_hi = mem[req.line][SLOTS-1];
        end else begin
            rd_lo = mem[req.line][req.slot];
            rd_hi = '0;
        end
    end

    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        !req.wr |=> $stable(mem_flat));

    p_single_store_r5: assert property (@(posedge clk) disable iff (rst)
        (req.wr && !req.dbl) |=>
        mem_flat[({$past(req.line), $past(req.slot)})*WORD_W +: WORD_W] == $past(lo_in));

    p_double_store_r6: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.dbl) |=>
        mem_flat[({$past(req.line), {SLOT_AW{1'b1}}})*WORD_W +: WORD_W] == $past(hi_in));
endmodule

// File: rtl/scratch_ldst_resp.sv
module scratch_ldst_resp
    import scratch_ldst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  req_t  req,
    input  word_t rd_lo,
    input  word_t rd_hi,
    output resp_t resp
);
    resp_t nxt;

    always_comb begin
        nxt       = '0;
        nxt.we_lo = req.rd;
        nxt.we_hi = req.rd && req.dbl;
        nxt.d_lo  = req.rd ? rd_lo : '0;
        nxt.d_hi  = (req.rd && req.dbl) ? rd_hi : '0;
        nxt.err   = req.range_err;
    end

    always_ff @(posedge clk) begin
        if (rst) resp <= '0;
        else     resp <= nxt;
    end

    p_hi_with_lo_r4: assert property (@(posedge clk) disable iff (rst)
        resp.we_hi |-> resp.we_lo);

    p_store_silent_r5: assert property (@(posedge clk) disable iff (rst)
        req.wr |=> (!resp.we_lo && !resp.we_hi));

    p_err_double_only_r7: assert property (@(posedge clk) disable iff (rst)
        resp.err |-> $past(req.dbl && (req.rd || req.wr)));

    p_enable_after_load_r10: assert property (@(posedge clk) disable iff (rst)
        resp.we_lo |-> $past(req.rd));
endmodule

// File: rtl/scratch_ldst.sv
module scratch_ldst
    import scratch_ldst_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_valid,
    input  logic [INSTR_W-1:0] ins,
    input  logic [WORD_W-1:0]  r6_in,
    input  logic [WORD_W-1:0]  r7_in,
    output logic               r6_we,
    output logic [WORD_W-1:0]  r6_wdata,
    output logic               r7_we,
    output logic [WORD_W-1:0]  r7_wdata,
    output logic               idx_err
);
    req_t  req;
    word_t rd_lo, rd_hi;
    resp_t resp;

    scratch_ldst_decode u_dec (
        .ins_valid (ins_valid),
        .ins       (ins),
        .req       (req)
    );

    scratch_ldst_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .lo_in (r6_in),
        .hi_in (r7_in),
        .rd_lo (rd_lo),
        .rd_hi (rd_hi)
    );

    scratch_ldst_resp u_resp (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .rd_lo (rd_lo),
        .rd_hi (rd_hi),
        .resp  (resp)
    );

    assign r6_we    = resp.we_lo;
    assign r7_we    = resp.we_hi;
    assign r6_wdata = resp.d_lo;
    assign r7_wdata = resp.d_hi;
    assign idx_err  = resp.err;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!r6_we && !r7_we && !idx_err && r6_wdata == '0 && r7_wdata == '0));
endmodule

// File: tb/scratch_ldst_tb.sv
module scratch_ldst_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       ins_valid;
    logic [8:0] ins;
    logic [5:0] r6_in, r7_in;
    logic       r6_we, r7_we, idx_err;
    logic [5:0] r6_wdata, r7_wdata;

    int total = 0;
    int bad   = 0;
    logic [5:0] model [8];

    always #4 clk = ~clk;

    scratch_ldst u_dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins(ins),
        .r6_in(r6_in), .r7_in(r7_in),
        .r6_we(r6_we), .r6_wdata(r6_wdata),
        .r7_we(r7_we), .r7_wdata(r7_wdata), .idx_err(idx_err)
    );

    function automatic logic [8:0] mk(input logic [2:0] op, input logic dbl,
                                      input logic [4:0] idx);
        return {op, dbl, idx};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one instruction right after a falling edge, check after the next one
    task automatic do_op(input logic v, input logic [2:0] op, input logic dbl,
                         input logic [4:0] idx, input logic [5:0] a,
                         input logic [5:0] b, input string tag_in);
        logic       e6, e7, ee;
        logic [5:0] d6, d7;
        logic       ld, st;
        string      tag;
        ld = v && op == 3'b101;
        st = v && op == 3'b110;
        e6 = ld; e7 = ld && dbl;
        d6 = '0; d7 = '0;
        ee = (ld || st) && dbl && (idx[4:2] != 3'b000);
        if (ld) begin
            if (dbl) begin
                d6 = model[{idx[1:0], 1'b0}];
                d7 = model[{idx[1:0], 1'b1}];
            end else d6 = model[idx[2:0]];
        end
        if (st) begin
            if (dbl) begin
                model[{idx[1:0], 1'b0}] = a;
                model[{idx[1:0], 1'b1}] = b;
            end else model[idx[2:0]] = a;
        end
        if (tag_in != "") tag = tag_in;
        else if (ld) tag = dbl ? "R4" : "R3";
        else if (st) tag = dbl ? "R6" : "R5";
        else tag = "R9";
        ins_valid = v; ins = mk(op, dbl, idx); r6_in = a; r7_in = b;
        @(negedge clk);
        chk(tag, "r6_we", {5'd0, r6_we}, {5'd0, e6});
        chk(tag, "r7_we", {5'd0, r7_we}, {5'd0, e7});
        chk(tag, "r6_wdata", r6_wdata, d6);
        chk(tag, "r7_wdata", r7_wdata, d7);
        chk((ee || idx_err) ? "R7" : tag, "idx_err", {5'd0, idx_err}, {5'd0, ee});
    endtask

    task automatic dump(input string tag);
        for (int l = 0; l < 4; l++) do_op(1'b1, 3'b101, 1'b1, 5'(l), '0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) model[i] = '0;
        rst = 1'b1; ins_valid = 1'b1; ins = mk(3'b101, 1'b1, 5'd0);
        r6_in = 6'h3f; r7_in = 6'h2a;
        @(negedge clk); @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "r6_we", {5'd0, r6_we}, 6'd0);
        chk("R1", "r7_we", {5'd0, r7_we}, 6'd0);
        chk("R1", "idx_err", {5'd0, idx_err}, 6'd0);
        chk("R1", "r6_wdata", r6_wdata, 6'd0);
        rst = 1'b0; ins_valid = 1'b0;
        @(negedge clk);
        chk("R1", "r6_we after reset", {5'd0, r6_we}, 6'd0);
        dump("R1");
        // R2/R5/R6: fill storage in both modes
        for (int w = 0; w < 8; w++) do_op(1'b1, 3'b110, 1'b0, 5'(w), 6'(w + 1), 6'h15, "R5");
        do_op(1'b1, 3'b110, 1'b1, 5'd2, 6'h21, 6'h32, "R6");
        dump("R2");
        for (int w = 0; w < 8; w++) do_op(1'b1, 3'b101, 1'b0, 5'(w), '0, '0, "R3");
        // R8: store then load same word immediately
        do_op(1'b1, 3'b110, 1'b0, 5'd5, 6'h2e, 6'h00, "R8");
        do_op(1'b1, 3'b101, 1'b0, 5'd5, 6'h00, 6'h00, "R8");
        do_op(1'b1, 3'b110, 1'b1, 5'd3, 6'h11, 6'h22, "R8");
        do_op(1'b1, 3'b101, 1'b1, 5'd3, 6'h00, 6'h00, "R8");
        // R7: upper index bits in double mode alias and flag
        do_op(1'b1, 3'b110, 1'b1, 5'b10101, 6'h0a, 6'h0b, "R7");
        do_op(1'b1, 3'b101, 1'b1, 5'b01001, 6'h00, 6'h00, "R7");
        do_op(1'b1, 3'b101, 1'b0, 5'b11111, 6'h00, 6'h00, "R7");
        // R9: unknown opcodes and invalid strobes change nothing
        for (int o = 0; o < 8; o++)
            if (o != 5 && o != 6) do_op(1'b1, 3'(o), 1'b1, 5'(o), 6'h3f, 6'h3f, "R9");
        do_op(1'b0, 3'b110, 1'b0, 5'd1, 6'h3c, 6'h3c, "R9");
        do_op(1'b0, 3'b110, 1'b1, 5'd0, 6'h3c, 6'h3c, "R9");
        dump("R9");
        // R10 and the rest: random mix
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            op = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'b101 : 3'b110);
            do_op(($urandom % 8) != 0, op, 1'($urandom), 5'($urandom),
                  6'($urandom), 6'($urandom), (n % 2 == 0) ? "" : "R10");
        end
        dump("R9");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule